// File: doc/BRIEF.md
# General-Purpose Register Bank with Address Pointers

This block holds the 32 byte-wide working registers of a small 8-bit load/store processor. The instruction decoder drives index and mode fields; the register bank answers with operand bytes through two byte read ports and one pair read port. It accepts a byte write or a 16-bit pair write each cycle. The pair write covers cases such as storing a multiply product into registers 1:0.

The top six registers also serve as three 16-bit indirect address pointers, each made of two neighbouring registers with the low byte in the even-numbered register. For a data access the decoder names a pointer and an addressing mode. The bank then outputs the effective address in the same cycle. For the post-increment and pre-decrement modes it also writes the adjusted pointer back at the next clock edge. If a write port and a pointer update aim at the same register, the pointer update wins.

Top module: `gpr_bank`

## Requirements
- R1: An active-high synchronous reset clears all 32 registers to zero, and no write or pointer update lands during a reset cycle.
- R2: Read ports A and B are combinational. Each returns the register named by its own 5-bit index, and each shows a written value from the first clock edge after the write.
- R3: With `wr_kind` = 1, byte write, `wr_data[7:0]` is stored into register `wr_idx` at the clock edge. With `wr_kind` = 0 (idle) or 3 (reserved), no register is written.
- R4: With `wr_kind` = 2, pair write, `wr_data[7:0]` goes to register 2n and `wr_data[15:8]` to register 2n+1, where n = `wr_idx[4:1]`. Bit 0 of `wr_idx` is ignored, so registers 1:0 take a full 16-bit result in one cycle.
- R5: The pair read port returns {register 2n+1, register 2n} for n = `rd_pair_idx`, combinationally.
- R6: `ptr_sel` picks the pointer: 0 is registers 27:26, 1 is registers 29:28, and 2 or 3 is registers 31:30. The even-numbered register is the low byte.
- R7: With `ptr_mode` = 1 (plain indirect), `eff_addr` equals the selected pointer, and the pointer is not changed.
- R8: With `ptr_mode` = 2 (post-increment), `eff_addr` equals the current pointer. At the edge the pointer becomes pointer+1 modulo 2^16, carrying from the low byte into the high byte, and 0xFFFF wraps to 0x0000.
- R9: With `ptr_mode` = 3 (pre-decrement), `eff_addr` equals pointer-1 modulo 2^16 in the same cycle, and that value is stored into the pointer at the edge. 0x0000 wraps to 0xFFFF.
- R10: With `ptr_mode` = 0 (no access), `eff_addr` is 0x0000 and no pointer changes.
- R11: When a post-increment or pre-decrement update and a byte or pair write target the same register in one cycle, that register takes the pointer value. A write to a register outside the pointer pair still lands in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 5 | Register index for read port A |
| rd_a_data | output | 8 | Read port A data |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_b_data | output | 8 | Read port B data |
| rd_pair_idx | input | 4 | Register pair index for the 16-bit read port |
| rd_pair_data | output | 16 | 16-bit pair read data |
| wr_kind | input | 2 | Write kind: 0 idle, 1 byte, 2 pair, 3 reserved |
| wr_idx | input | 5 | Write target register (bit 0 ignored for pair writes) |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| ptr_sel | input | 2 | Pointer select: 0 low pointer, 1 middle, 2 or 3 top |
| ptr_mode | input | 2 | Addressing mode: 0 none, 1 plain, 2 post-increment, 3 pre-decrement |
| eff_addr | output | 16 | Effective data address for the current access |

## Verification
The effective address is combinational, so the bench samples it one time unit after it drives the mode and pointer select at a falling edge, before the next rising edge. Register contents change only at the rising edge that follows the request. Every register and pointer check therefore reads back through a read port at the next falling edge, after the write and pointer inputs have returned to idle, so the value seen is the one stored at that single edge. The reset checks use the same one-edge delay: a write requested during a reset cycle is read back at the falling edge after that edge.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    // Default geometry of the bank
    localparam int unsigned GPR_COUNT    = 32;
    localparam int unsigned GPR_WIDTH    = 8;
    localparam int unsigned GPR_PTR_BASE = 26;
    localparam int unsigned GPR_PTR_NUM  = 3;

    // Kind of write requested on the write port
    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_BYTE = 2'd1,
        WK_PAIR = 2'd2,
        WK_RSVD = 2'd3
    } wr_kind_e;

    // Addressing mode for a pointer-based data access
    typedef enum logic [1:0] {
        PM_NONE    = 2'd0,
        PM_PLAIN   = 2'd1,
        PM_POSTINC = 2'd2,
        PM_PREDEC  = 2'd3
    } ptr_mode_e;

    // Which source feeds a register at the next edge
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_BYTE = 2'd1,
        SRC_PAIR = 2'd2,
        SRC_PTR  = 2'd3
    } reg_src_e;

    // Pointer modes that write back an adjusted value
    function automatic logic mode_updates(input ptr_mode_e m);
        return (m == PM_POSTINC) || (m == PM_PREDEC);
    endfunction

    // Write kinds that modify the bank
    function automatic logic kind_writes(input wr_kind_e k);
        return (k == WK_BYTE) || (k == WK_PAIR);
    endfunction

endpackage

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
    import gpr_pkg::*;
#(
    parameter int unsigned REG_W    = GPR_WIDTH,
    parameter int unsigned NUM_PTRS = GPR_PTR_NUM,
    parameter int unsigned PAIR_W   = 4,
    parameter int unsigned PTR_BASE = GPR_PTR_BASE,
    localparam int unsigned ADDR_W  = 2 * REG_W,
    localparam int unsigned PSEL_W  = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1
) (
    input  logic [2*NUM_PTRS-1:0][REG_W-1:0] ptr_regs,
    input  logic [PSEL_W-1:0]                sel,
    input  ptr_mode_e                        mode,
    output logic [ADDR_W-1:0]                eff_addr,
    output logic                             upd_en,
    output logic [PAIR_W-1:0]                upd_pair,
    output logic [ADDR_W-1:0]                upd_val
);

    localparam int unsigned BASE_PAIR = PTR_BASE / 2;

    logic [ADDR_W-1:0] ptr_vals [NUM_PTRS];
    logic [PSEL_W-1:0] slot;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] cur_inc;
    logic [ADDR_W-1:0] cur_dec;

    // Assemble each pointer from its register pair, low byte even
    for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
        assign ptr_vals[p] = {ptr_regs[2*p+1], ptr_regs[2*p]};
    end

    // Selects beyond the last pointer alias onto the last pointer
    always_comb begin
        if (32'(sel) >= NUM_PTRS) begin
            slot = PSEL_W'(NUM_PTRS - 1);
        end else begin
            slot = sel;
        end
    end

    assign cur     = ptr_vals[slot];
    assign cur_inc = cur + ADDR_W'(1);
    assign cur_dec = cur - ADDR_W'(1);

    always_comb begin
        unique case (mode)
            PM_PLAIN:   eff_addr = cur;
            PM_POSTINC: eff_addr = cur;
            PM_PREDEC:  eff_addr = cur_dec;
            default:    eff_addr = '0;
        endcase
    end

    assign upd_en   = mode_updates(mode);
    assign upd_val  = (mode == PM_PREDEC) ? cur_dec : cur_inc;
    assign upd_pair = PAIR_W'(BASE_PAIR) + PAIR_W'(slot);

endmodule

// File: rtl/gpr_wr_merge.sv
module gpr_wr_merge
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS = GPR_COUNT,
    parameter int unsigned REG_W    = GPR_WIDTH,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned PAIR_W  = IDX_W - 1,
    localparam int unsigned ADDR_W  = 2 * REG_W
) (
    input  wr_kind_e                         kind,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [ADDR_W-1:0]                data,
    input  logic                             upd_en,
    input  logic [PAIR_W-1:0]                upd_pair,
    input  logic [ADDR_W-1:0]                upd_val,
    output logic [NUM_REGS-1:0]              we,
    output logic [NUM_REGS-1:0][REG_W-1:0]   wd
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic              IS_HI  = (i % 2) == 1;
        localparam logic [PAIR_W-1:0] MY_PAIR = PAIR_W'(i / 2);

        reg_src_e src;
        logic     byte_hit;
        logic     pair_hit;
        logic     ptr_hit;

        assign byte_hit = (kind == WK_BYTE) && (idx == IDX_W'(i));
        assign pair_hit = (kind == WK_PAIR) && (idx[IDX_W-1:1] == MY_PAIR);
        assign ptr_hit  = upd_en && (upd_pair == MY_PAIR);

        // Pointer update outranks both write kinds
        always_comb begin
            if (ptr_hit) begin
                src = SRC_PTR;
            end else if (pair_hit) begin
                src = SRC_PAIR;
            end else if (byte_hit) begin
                src = SRC_BYTE;
            end else begin
                src = SRC_HOLD;
            end
        end

        always_comb begin
            unique case (src)
                SRC_PTR:  wd[i] = IS_HI ? upd_val[ADDR_W-1:REG_W] : upd_val[REG_W-1:0];
                SRC_PAIR: wd[i] = IS_HI ? data[ADDR_W-1:REG_W] : data[REG_W-1:0];
                SRC_BYTE: wd[i] = data[REG_W-1:0];
                default:  wd[i] = '0;
            endcase
        end

        assign we[i] = (src != SRC_HOLD);
    end

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS = GPR_COUNT,
    parameter int unsigned REG_W    = GPR_WIDTH
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_REGS-1:0]            we,
    input  logic [NUM_REGS-1:0][REG_W-1:0] wd,
    output logic [NUM_REGS-1:0][REG_W-1:0] q
);

    logic [REG_W-1:0] cells [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= '0;
            end else if (we[i]) begin
                cells[i] <= wd[i];
            end
        end
        assign q[i] = cells[i];
    end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS = GPR_COUNT,
    parameter int unsigned REG_W    = GPR_WIDTH,
    parameter int unsigned PTR_BASE = GPR_PTR_BASE,
    parameter int unsigned NUM_PTRS = GPR_PTR_NUM,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned PAIR_W  = IDX_W - 1,
    localparam int unsigned ADDR_W  = 2 * REG_W,
    localparam int unsigned PSEL_W  = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1,
    localparam int unsigned PTR_TOP = PTR_BASE + 2 * NUM_PTRS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [REG_W-1:0]  rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [REG_W-1:0]  rd_b_data,
    input  logic [PAIR_W-1:0] rd_pair_idx,
    output logic [ADDR_W-1:0] rd_pair_data,
    input  logic [1:0]        wr_kind,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PSEL_W-1:0] ptr_sel,
    input  logic [1:0]        ptr_mode,
    output logic [ADDR_W-1:0] eff_addr
);

    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
    logic [NUM_REGS-1:0][REG_W-1:0] regs_wd;
    logic [NUM_REGS-1:0]            regs_we;
    logic                           upd_en;
    logic [PAIR_W-1:0]              upd_pair;
    logic [ADDR_W-1:0]              upd_val;
    wr_kind_e                       kind;
    ptr_mode_e                      mode;

    assign kind = wr_kind_e'(wr_kind);
    assign mode = ptr_mode_e'(ptr_mode);

    gpr_ptr_unit #(
        .REG_W    (REG_W),
        .NUM_PTRS (NUM_PTRS),
        .PAIR_W   (PAIR_W),
        .PTR_BASE (PTR_BASE)
    ) u_ptr (
        .ptr_regs (regs_q[PTR_TOP:PTR_BASE]),
        .sel      (ptr_sel),
        .mode     (mode),
        .eff_addr (eff_addr),
        .upd_en   (upd_en),
        .upd_pair (upd_pair),
        .upd_val  (upd_val)
    );

    gpr_wr_merge #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_merge (
        .kind     (kind),
        .idx      (wr_idx),
        .data     (wr_data),
        .upd_en   (upd_en),
        .upd_pair (upd_pair),
        .upd_val  (upd_val),
        .we       (regs_we),
        .wd       (regs_wd)
    );

    gpr_storage #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_store (
        .clk (clk),
        .rst (rst),
        .we  (regs_we),
        .wd  (regs_wd),
        .q   (regs_q)
    );

    // Combinational read ports
    assign rd_a_data    = regs_q[rd_a_idx];
    assign rd_b_data    = regs_q[rd_b_idx];
    assign rd_pair_data = {regs_q[{rd_pair_idx, 1'b1}], regs_q[{rd_pair_idx, 1'b0}]};

endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS = GPR_COUNT,
    parameter int unsigned REG_W    = GPR_WIDTH,
    parameter int unsigned PTR_BASE = GPR_PTR_BASE,
    parameter int unsigned NUM_PTRS = GPR_PTR_NUM,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned ADDR_W  = 2 * REG_W,
    localparam int unsigned PSEL_W  = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1
) (
    input logic                           clk,
    input logic                           rst,
    input logic [1:0]                     wr_kind,
    input logic [IDX_W-1:0]               wr_idx,
    input logic [ADDR_W-1:0]              wr_data,
    input logic [PSEL_W-1:0]              ptr_sel,
    input logic [1:0]                     ptr_mode,
    input logic [ADDR_W-1:0]              eff_addr,
    input logic [NUM_REGS-1:0][REG_W-1:0] regs_q
);

    logic [IDX_W-1:0]  lo_idx;
    logic [ADDR_W-1:0] cur;
    logic              upd;
    logic              clash;
    logic              rst_q = 1'b0;

    always_comb begin
        if (32'(ptr_sel) >= NUM_PTRS) begin
            lo_idx = IDX_W'(PTR_BASE + 2 * (NUM_PTRS - 1));
        end else begin
            lo_idx = IDX_W'(PTR_BASE) + IDX_W'({ptr_sel, 1'b0});
        end
    end

    function automatic logic [ADDR_W-1:0] pair_at(input logic [IDX_W-1:0] lo);
        return {regs_q[{lo[IDX_W-1:1], 1'b1}], regs_q[{lo[IDX_W-1:1], 1'b0}]};
    endfunction

    assign cur   = pair_at(lo_idx);
    assign upd   = (ptr_mode == 2'd2) || (ptr_mode == 2'd3);
    assign clash = upd && (wr_idx[IDX_W-1:1] == lo_idx[IDX_W-1:1]);

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: one edge after reset every register reads zero
    always @(negedge clk) begin
        if (rst_q) begin
            a_r1_reset_clear: assert (regs_q == '0);
        end
    end

    // R10
    a_r10_idle_addr: assert property (@(posedge clk) disable iff (rst)
        (ptr_mode == 2'd0) |-> (eff_addr == '0));

    // R7
    a_r7_plain_addr: assert property (@(posedge clk) disable iff (rst)
        (ptr_mode == 2'd1) |-> (eff_addr == cur));

    // R7
    a_r7_plain_hold: assert property (@(posedge clk) disable iff (rst)
        (ptr_mode == 2'd1 && wr_kind == 2'd0) |=> (pair_at($past(lo_idx)) == $past(cur)));

    // R8
    a_r8_postinc_addr: assert property (@(posedge clk) disable iff (rst)
        (ptr_mode == 2'd2) |-> (eff_addr == cur));

    // R8, R11: the increment lands even when a write aims at the pair
    a_r8_postinc_step: assert property (@(posedge clk) disable iff (rst)
        (ptr_mode == 2'd2) |=> (pair_at($past(lo_idx)) == ADDR_W'($past(cur) + ADDR_W'(1))));

    // R9
    a_r9_predec_addr: assert property (@(posedge clk) disable iff (rst)
        (ptr_mode == 2'd3) |-> (eff_addr == ADDR_W'(cur - ADDR_W'(1))));

    // R9, R11
    a_r9_predec_store: assert property (@(posedge clk) disable iff (rst)
        (ptr_mode == 2'd3) |=> (pair_at($past(lo_idx)) == $past(eff_addr)));

    // R3
    a_r3_byte_write: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == 2'd1 && !clash) |=> (regs_q[$past(wr_idx)] == $past(wr_data[REG_W-1:0])));

    // R4
    a_r4_pair_write: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == 2'd2 && !clash) |=> (pair_at($past(wr_idx)) == $past(wr_data)));

endmodule

bind gpr_bank gpr_bank_chk #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .PTR_BASE (PTR_BASE),
    .NUM_PTRS (NUM_PTRS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_kind  (wr_kind),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .ptr_sel  (ptr_sel),
    .ptr_mode (ptr_mode),
    .eff_addr (eff_addr),
    .regs_q   (regs_q)
);

// File: tb/test_gpr_bank.sv
module test_gpr_bank;

    typedef struct packed {
        logic [1:0]  wk;
        logic [4:0]  widx;
        logic [15:0] wdata;
        logic [1:0]  psel;
        logic [1:0]  pmode;
        logic [15:0] exp_ea;
        logic [4:0]  cidx;
        logic [7:0]  cval;
    } vec_t;

    localparam int NVEC = 17;

    // wk: 0 idle,1 byte,2 pair,3 rsvd ; pmode: 0 none,1 plain,2 postinc,3 predec
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 5'd5,  16'h003C, 2'd0, 2'd0, 16'h0000, 5'd5,  8'h3C}, // R3 byte write
        '{2'd2, 5'd26, 16'h1234, 2'd0, 2'd0, 16'h0000, 5'd27, 8'h12}, // R4 pair write X
        '{2'd0, 5'd0,  16'h0000, 2'd0, 2'd1, 16'h1234, 5'd26, 8'h34}, // R7 plain X
        '{2'd0, 5'd0,  16'h0000, 2'd0, 2'd2, 16'h1234, 5'd26, 8'h35}, // R8 postinc X
        '{2'd0, 5'd0,  16'h0000, 2'd0, 2'd3, 16'h1234, 5'd26, 8'h34}, // R9 predec X
        '{2'd2, 5'd29, 16'hFFFF, 2'd1, 2'd0, 16'h0000, 5'd28, 8'hFF}, // R4 odd idx
        '{2'd0, 5'd0,  16'h0000, 2'd1, 2'd2, 16'hFFFF, 5'd29, 8'h00}, // R8 wrap
        '{2'd0, 5'd0,  16'h0000, 2'd1, 2'd3, 16'hFFFF, 5'd28, 8'hFF}, // R9 wrap
        '{2'd2, 5'd1,  16'hBEEF, 2'd0, 2'd0, 16'h0000, 5'd0,  8'hEF}, // R4 r1:r0
        '{2'd2, 5'd30, 16'h00FF, 2'd2, 2'd0, 16'h0000, 5'd31, 8'h00}, // R4 Z
        '{2'd0, 5'd0,  16'h0000, 2'd3, 2'd2, 16'h00FF, 5'd31, 8'h01}, // R6 sel3, carry
        '{2'd1, 5'd30, 16'h00AA, 2'd2, 2'd2, 16'h0100, 5'd30, 8'h01}, // R11 byte loses
        '{2'd2, 5'd30, 16'h5555, 2'd2, 2'd3, 16'h0100, 5'd31, 8'h01}, // R11 pair loses
        '{2'd1, 5'd3,  16'h0077, 2'd0, 2'd2, 16'h1234, 5'd3,  8'h77}, // R11 other reg
        '{2'd0, 5'd0,  16'h0000, 2'd0, 2'd0, 16'h0000, 5'd26, 8'h35}, // R8 X advanced
        '{2'd0, 5'd5,  16'h00EE, 2'd0, 2'd0, 16'h0000, 5'd5,  8'h3C}, // R3 idle kind
        '{2'd3, 5'd26, 16'h0099, 2'd0, 2'd0, 16'h0000, 5'd26, 8'h35}  // R3 rsvd, R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0;
    logic [7:0]  rd_a_data;
    logic [4:0]  rd_b_idx = '0;
    logic [7:0]  rd_b_data;
    logic [3:0]  rd_pair_idx = '0;
    logic [15:0] rd_pair_data;
    logic [1:0]  wr_kind = '0;
    logic [4:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  ptr_sel = '0;
    logic [1:0]  ptr_mode = '0;
    logic [15:0] eff_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpr_bank i_gpr_bank (
        .clk          (clk),
        .rst          (rst),
        .rd_a_idx     (rd_a_idx),
        .rd_a_data    (rd_a_data),
        .rd_b_idx     (rd_b_idx),
        .rd_b_data    (rd_b_data),
        .rd_pair_idx  (rd_pair_idx),
        .rd_pair_data (rd_pair_data),
        .wr_kind      (wr_kind),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .ptr_sel      (ptr_sel),
        .ptr_mode     (ptr_mode),
        .eff_addr     (eff_addr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        wr_kind  = 2'd0;
        wr_idx   = '0;
        wr_data  = '0;
        ptr_mode = 2'd0;
        ptr_sel  = 2'd0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(31 - i);
            #1;
            check("R1 reset A", {8'h00, rd_a_data}, 16'h0000);
            check("R1 reset B", {8'h00, rd_b_data}, 16'h0000);
        end
        check("R10 idle eff_addr", eff_addr, 16'h0000);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            wr_kind  = VECS[v].wk;
            wr_idx   = VECS[v].widx;
            wr_data  = VECS[v].wdata;
            ptr_sel  = VECS[v].psel;
            ptr_mode = VECS[v].pmode;
            #1;
            check($sformatf("R6-mapped eff_addr vec %0d (R7 R8 R9 R10)", v), eff_addr, VECS[v].exp_ea);
            @(negedge clk);
            go_idle();
            rd_a_idx = VECS[v].cidx;
            #1;
            check($sformatf("R2 R3 R4 R11 reg vec %0d", v), {8'h00, rd_a_data}, {8'h00, VECS[v].cval});
        end

        // R2: both byte ports at once
        rd_a_idx = 5'd5;
        rd_b_idx = 5'd1;
        #1;
        check("R2 port A", {8'h00, rd_a_data}, 16'h003C);
        check("R2 port B", {8'h00, rd_b_data}, 16'h00BE);
        rd_b_idx = 5'd3;
        #1;
        check("R2 port B second", {8'h00, rd_b_data}, 16'h0077);

        // R5: pair read port
        rd_pair_idx = 4'd0;
        #1;
        check("R5 pair r1:r0", rd_pair_data, 16'hBEEF);
        rd_pair_idx = 4'd13;
        #1;
        check("R5 pair X", rd_pair_data, 16'h1235);
        rd_pair_idx = 4'd14;
        #1;
        check("R5 pair Y", rd_pair_data, 16'hFFFF);
        rd_pair_idx = 4'd15;
        #1;
        check("R5 pair Z", rd_pair_data, 16'h0100);

        // R9: pre-decrement from zero wraps, via freshly written pointer
        @(negedge clk);
        wr_kind = 2'd2; wr_idx = 5'd26; wr_data = 16'h0000;
        @(negedge clk);
        go_idle();
        ptr_sel = 2'd0; ptr_mode = 2'd3;
        #1;
        check("R9 predec zero eff_addr", eff_addr, 16'hFFFF);
        @(negedge clk);
        go_idle();
        rd_pair_idx = 4'd13;
        #1;
        check("R9 predec zero store", rd_pair_data, 16'hFFFF);

        // R1: write requested during reset does not land
        @(negedge clk);
        rst = 1'b1;
        wr_kind = 2'd1; wr_idx = 5'd5; wr_data = 16'h0099;
        ptr_sel = 2'd1; ptr_mode = 2'd2;
        @(negedge clk);
        go_idle();
        rst = 1'b0;
        rd_a_idx = 5'd5;
        rd_pair_idx = 4'd14;
        #1;
        check("R1 reset blocks write", {8'h00, rd_a_data}, 16'h0000);
        check("R1 reset blocks pointer", rd_pair_data, 16'h0000);
        rd_pair_idx = 4'd0;
        #1;
        check("R1 reset clears r1:r0", rd_pair_data, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule